// File: doc/BRIEF.md
# Character-Row CRT Timing Generator

This block produces the raster timing for a character-mapped display. One clock edge is one character time. A horizontal character counter, a raster counter inside each character row and a vertical row counter together define the frame. From these counters the block drives the following outputs:

- a horizontal sync pulse and a vertical sync pulse, each with a programmable width;
- a display-enable signal, which is low in the border;
- a 14-bit video memory address and a raster address.

The memory address starts each frame at a programmable start address, which is how hardware scrolling works. Each character row then continues from where the previous row's visible part ended.

A host programs the block through an indexed register file. First it writes an index with `hostSel` = 0, then it writes data to the indexed register with `hostSel` = 1. The `hostRData` output always shows the register that the current index selects. In this variant, a horizontal sync width of zero produces no pulse, and a vertical sync width of zero produces 16 lines. While the row counter is zero, the start address is reloaded at every scanline, so the start address can change from one line to the next at the top of the frame.

Register indexes:

| Index | Contents |
|---|---|
| 0 | Horizontal total minus one (T) |
| 1 | Displayed characters per line (D) |
| 2 | Horizontal sync position (P) |
| 3 | Sync widths: bits 3..0 give the horizontal width in characters, bits 7..4 give the vertical width in lines |
| 4 | Vertical total rows minus one (V), 7 bits |
| 6 | Displayed rows (E), 7 bits |
| 7 | Vertical sync row (S), 7 bits |
| 9 | Last raster of a row (M), 5 bits |
| 12 | Start address, high 6 bits |
| 13 | Start address, low 8 bits |
| 14 | Spare address register, high 6 bits |
| 15 | Spare address register, low 8 bits |

Top module: `crtTimingGen`

## Requirements
- R1: Each clock advances the character counter. The counter returns to 0 after the clock in which it equals T, so a line lasts T+1 clocks. `ra` counts 0..M and then returns to 0 while the row counter advances. After row V finishes, the frame restarts at row 0.
- R2: `dispEn` is 1 exactly when the character counter is below D and the row counter is below E.
- R3: `hSync` goes high in the clock in which the character counter equals P and stays high for W clocks, where W is bits 3..0 of index 3. When W = 0, `hSync` never goes high.
- R4: `vSync` goes high for the whole line at raster 0 of row S and stays high for N lines, where N is bits 7..4 of index 3. When N = 0, the pulse lasts 16 lines.
- R5: `ma` increases by 1 every clock within a line. At the last raster of a row, the value of `ma` when the character counter equals D becomes the base address of every line in the next row. The address wraps modulo 2^14.
- R6: Every line that belongs to row 0 starts at the start address that is in the registers at the end of the previous line. A change to index 13 made in the middle of a line in row 0 therefore moves the next line.
- R7: When E = 0, `dispEn` stays 0 for the whole frame.
- R8: Reading index 12 or 14 returns the stored 6 bits with bits 7..6 at 0. Reading index 13 or 15 returns the stored byte. Index 31 reads 0xFF whatever was written to it. Indexes 16 to 30, and the write-only indexes 0 to 11, read 0.
- R9: While `rstN` is low, the counters hold at 0, `ma` equals the start address, and both sync pulses are idle unless their start condition holds at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Synchronous active-low reset of the counters and the sync state |
| hostWe | input | 1 | Host write strobe |
| hostSel | input | 1 | 0 selects the index register, 1 selects the indexed data register |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Contents of the register that the current index selects |
| hSync | output | 1 | Horizontal sync pulse |
| vSync | output | 1 | Vertical sync pulse |
| dispEn | output | 1 | High in the active area, low in the border |
| ma | output | 14 | Video memory address |
| ra | output | 5 | Raster address within the character row |

## Verification
The bench runs four timing setups, and every output is compared on every clock over two or more frames.

- **Mid-width horizontal and vertical sync.** This setup checks basic counter sequencing and row-to-row address carry.
- **Both sync-width fields at zero.** This setup separates the suppressed horizontal pulse from the 16-line vertical pulse. In this setup the vertical pulse runs across the frame boundary and the start address sits near the top of the address space, so it also exercises the 14-bit wrap.
- **Displayed-row count of zero.** This setup uses a horizontal pulse that wraps past the line end and a vertical pulse on row 0. It shows that the border covers the whole frame.
- **Mid-line write to the start address in row 0.** This setup tells the per-line reload apart from a reload that happens only once per frame.

Register readback is checked separately, with values chosen so that the masked bits are set.

// File: rtl/crtPkg.sv
package crtPkg;
  localparam int H_W    = 8;
  localparam int RA_W   = 5;
  localparam int V_W    = 7;
  localparam int MA_W   = 14;
  localparam int SW_W   = 4;
  localparam int DATA_W = 8;
  localparam int HI_W   = MA_W - DATA_W;

  localparam int IX_HTOTAL   = 0;
  localparam int IX_HDISP    = 1;
  localparam int IX_HSPOS    = 2;
  localparam int IX_SYNCW    = 3;
  localparam int IX_VTOTAL   = 4;
  localparam int IX_VDISP    = 6;
  localparam int IX_VSROW    = 7;
  localparam int IX_MAXRAS   = 9;
  localparam int IX_START_HI = 12;
  localparam int IX_START_LO = 13;
  localparam int IX_SPARE_HI = 14;
  localparam int IX_SPARE_LO = 15;
  localparam int IX_ONES     = 31;

  typedef struct packed {
    logic [H_W-1:0]  hTotal;
    logic [H_W-1:0]  hDisp;
    logic [H_W-1:0]  hsPos;
    logic [SW_W-1:0] hsWidth;
    logic [SW_W-1:0] vsWidth;
    logic [V_W-1:0]  vTotal;
    logic [V_W-1:0]  vDisp;
    logic [V_W-1:0]  vsRow;
    logic [RA_W-1:0] maxRaster;
  } crtTiming_t;

  typedef struct packed {
    logic lineEnd;
    logic nextRowZero;
    logic capture;
  } crtStrobe_t;
endpackage

// File: rtl/crtRegFile.sv
module crtRegFile
  import crtPkg::*;
(
  input  logic              clk,
  input  logic              hostWe,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostWData,
  output logic [DATA_W-1:0] hostRData,
  output crtTiming_t        tim,
  output logic [MA_W-1:0]   startAddr
);
  logic [DATA_W-1:0] idxQ;
  logic [HI_W-1:0]   startHi;
  logic [DATA_W-1:0] startLo;
  logic [HI_W-1:0]   spareHi;
  logic [DATA_W-1:0] spareLo;

  // index register and data registers; register 31 and unknown indexes ignore writes
  always_ff @(posedge clk) begin
    if (hostWe) begin
      if (!hostSel) begin
        idxQ <= hostWData;
      end else begin
        case (int'(idxQ))
          IX_HTOTAL:   tim.hTotal    <= hostWData[H_W-1:0];
          IX_HDISP:    tim.hDisp     <= hostWData[H_W-1:0];
          IX_HSPOS:    tim.hsPos     <= hostWData[H_W-1:0];
          IX_SYNCW: begin
            tim.hsWidth <= hostWData[SW_W-1:0];
            tim.vsWidth <= hostWData[2*SW_W-1:SW_W];
          end
          IX_VTOTAL:   tim.vTotal    <= hostWData[V_W-1:0];
          IX_VDISP:    tim.vDisp     <= hostWData[V_W-1:0];
          IX_VSROW:    tim.vsRow     <= hostWData[V_W-1:0];
          IX_MAXRAS:   tim.maxRaster <= hostWData[RA_W-1:0];
          IX_START_HI: startHi       <= hostWData[HI_W-1:0];
          IX_START_LO: startLo       <= hostWData;
          IX_SPARE_HI: spareHi       <= hostWData[HI_W-1:0];
          IX_SPARE_LO: spareLo       <= hostWData;
          default: ;
        endcase
      end
    end
  end

  assign startAddr = {startHi, startLo};

  always_comb begin
    case (int'(idxQ))
      IX_START_HI: hostRData = {{(DATA_W-HI_W){1'b0}}, startHi};
      IX_START_LO: hostRData = startLo;
      IX_SPARE_HI: hostRData = {{(DATA_W-HI_W){1'b0}}, spareHi};
      IX_SPARE_LO: hostRData = spareLo;
      IX_ONES:     hostRData = '1;
      default:     hostRData = '0;
    endcase
  end
endmodule

// File: rtl/crtPulse.sv
module crtPulse #(
  parameter int CW = 4,
  parameter bit ZERO_MEANS_MAX = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigger,
  input  logic          advance,
  input  logic [CW-1:0] width,
  output logic          active
);
  logic [CW:0]   wEff;
  logic [CW:0]   wLess;
  logic [CW-1:0] left;
  logic          startNow;

  generate
    if (ZERO_MEANS_MAX) begin : g_zeroMax
      assign wEff = (width == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, width};
    end else begin : g_zeroNone
      assign wEff = {1'b0, width};
    end
  endgenerate

  assign startNow = trigger && (wEff != '0);
  assign wLess    = wEff - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      left <= '0;
    end else if (advance) begin
      if (startNow)          left <= wLess[CW-1:0];
      else if (left != '0)   left <= left - 1'b1;
    end
  end

  assign active = startNow || (left != '0);
endmodule

// File: rtl/crtCtrl.sv
module crtCtrl
  import crtPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  crtTiming_t      tim,
  output logic [H_W-1:0]  hCnt,
  output logic [RA_W-1:0] rCnt,
  output logic [V_W-1:0]  vCnt,
  output crtStrobe_t      strb,
  output logic            hSync,
  output logic            vSync,
  output logic            dispEn
);
  logic hEnd, rEnd, vEnd;

  assign hEnd = (hCnt == tim.hTotal);
  assign rEnd = (rCnt == tim.maxRaster);
  assign vEnd = (vCnt == tim.vTotal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
      rCnt <= '0;
      vCnt <= '0;
    end else if (hEnd) begin
      hCnt <= '0;
      if (rEnd) begin
        rCnt <= '0;
        vCnt <= vEnd ? '0 : vCnt + 1'b1;
      end else begin
        rCnt <= rCnt + 1'b1;
      end
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  assign strb.lineEnd     = hEnd;
  assign strb.nextRowZero = rEnd ? vEnd : (vCnt == '0);
  assign strb.capture     = rEnd && (hCnt == tim.hDisp);

  assign dispEn = (hCnt < tim.hDisp) && (vCnt < tim.vDisp);

  crtPulse #(.CW(SW_W), .ZERO_MEANS_MAX(1'b0)) hPulse_i (
    .clk    (clk),
    .rstN   (rstN),
    .trigger(hCnt == tim.hsPos),
    .advance(1'b1),
    .width  (tim.hsWidth),
    .active (hSync)
  );

  crtPulse #(.CW(SW_W), .ZERO_MEANS_MAX(1'b1)) vPulse_i (
    .clk    (clk),
    .rstN   (rstN),
    .trigger((vCnt == tim.vsRow) && (rCnt == '0)),
    .advance(hEnd),
    .width  (tim.vsWidth),
    .active (vSync)
  );
endmodule

// File: rtl/crtAddr.sv
module crtAddr
  import crtPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  crtStrobe_t      strb,
  input  logic [MA_W-1:0] startAddr,
  output logic [MA_W-1:0] ma
);
  logic [MA_W-1:0] maCnt;
  logic [MA_W-1:0] rowBase;
  logic [MA_W-1:0] nextLine;

  assign nextLine = strb.nextRowZero ? startAddr :
                    (strb.capture ? maCnt : rowBase);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maCnt   <= startAddr;
      rowBase <= startAddr;
    end else begin
      if (strb.capture) rowBase <= maCnt;
      if (strb.lineEnd) maCnt <= nextLine;
      else              maCnt <= maCnt + 1'b1;
    end
  end

  assign ma = maCnt;
endmodule

// File: rtl/crtTimingGen.sv
module crtTimingGen
  import crtPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostWData,
  output logic [DATA_W-1:0] hostRData,
  output logic              hSync,
  output logic              vSync,
  output logic              dispEn,
  output logic [MA_W-1:0]   ma,
  output logic [RA_W-1:0]   ra
);
  crtTiming_t      tim;
  logic [MA_W-1:0] startAddr;
  crtStrobe_t      strb;
  logic [H_W-1:0]  hCnt;
  logic [V_W-1:0]  vCnt;

  crtRegFile regs_i (
    .clk      (clk),
    .hostWe   (hostWe),
    .hostSel  (hostSel),
    .hostWData(hostWData),
    .hostRData(hostRData),
    .tim      (tim),
    .startAddr(startAddr)
  );

  crtCtrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .tim   (tim),
    .hCnt  (hCnt),
    .rCnt  (ra),
    .vCnt  (vCnt),
    .strb  (strb),
    .hSync (hSync),
    .vSync (vSync),
    .dispEn(dispEn)
  );

  crtAddr addr_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startAddr(startAddr),
    .ma       (ma)
  );
endmodule

// File: rtl/crtTimingChk.sv
module crtTimingChk
  import crtPkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            hSync,
  input logic            vSync,
  input logic            dispEn,
  input logic [MA_W-1:0] ma,
  input logic [RA_W-1:0] ra,
  input logic [H_W-1:0]  hCnt,
  input logic [V_W-1:0]  vCnt,
  input logic [H_W-1:0]  hTotal,
  input logic [V_W-1:0]  vsRow,
  input logic [SW_W-1:0] hsWidth
);
  // R1
  ra_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ra != $past(ra)) |-> (ra == '0 || ra == $past(ra) + 1'b1));

  // R5
  ma_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(hCnt) != $past(hTotal)) |-> (ma == $past(ma) + 1'b1));

  // R3
  hs_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsWidth == '0) |-> !hSync);

  // R4
  vs_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(vSync)) |-> (ra == '0 && vCnt == vsRow));

  // R2
  disp_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(dispEn)) |-> (hCnt == '0));
endmodule

bind crtTimingGen crtTimingChk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .hSync  (hSync),
  .vSync  (vSync),
  .dispEn (dispEn),
  .ma     (ma),
  .ra     (ra),
  .hCnt   (hCnt),
  .vCnt   (vCnt),
  .hTotal (tim.hTotal),
  .vsRow  (tim.vsRow),
  .hsWidth(tim.hsWidth)
);

// File: tb/crtTimingGen_tb_top.sv
module crtTimingGen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, hostWe, hostSel;
  logic [7:0]  hostWData, hostRData;
  logic        hSync, vSync, dispEn;
  logic [13:0] ma;
  logic [4:0]  ra;

  int checks = 0;
  int errors = 0;
  int pH0, pH1, pH2, pSw, pV4, pV6, pV7, pR9, pS;

  crtTimingGen dut_i (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWData(hostWData), .hostRData(hostRData), .hSync(hSync),
    .vSync(vSync), .dispEn(dispEn), .ma(ma), .ra(ra)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  task automatic wr(int idx, int val);
    @(negedge clk); hostWe = 1'b1; hostSel = 1'b0; hostWData = 8'(idx);
    @(negedge clk); hostSel = 1'b1; hostWData = 8'(val);
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic rdChk(int idx, int exp, string req);
    @(negedge clk); hostWe = 1'b1; hostSel = 1'b0; hostWData = 8'(idx);
    @(negedge clk); hostWe = 1'b0;
    check(req, $sformatf("readback of index %0d", idx), int'(hostRData), exp);
  endtask

  task automatic setCfg(int h0, int h1, int h2, int sw, int v4, int v6, int v7, int r9, int s);
    rstN = 1'b0;
    pH0 = h0; pH1 = h1; pH2 = h2; pSw = sw; pV4 = v4; pV6 = v6; pV7 = v7; pR9 = r9; pS = s;
    wr(0, h0); wr(1, h1); wr(2, h2); wr(3, sw); wr(4, v4);
    wr(6, v6); wr(7, v7); wr(9, r9); wr(12, (s >> 8) & 63); wr(13, s & 255);
    @(negedge clk);
  endtask

  // runs from reset release, modelling every output per clock
  task automatic sweep(int cycles, string dReq, string mReq, int midAt, int newS);
    int mh = 0, mr = 0, mv = 0, g = 0;
    int curS = pS;
    int base = pS;
    int lastBase = pS;
    int lineLen = pH0 + 1;
    int wh = pSw & 15;
    int vf = (pSw >> 4) & 15;
    int wv = (vf == 0) ? 16 : vf;
    int ls = pV7 * (pR9 + 1);
    int fl = (pV4 + 1) * (pR9 + 1);
    rstN = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      if (c == midAt) begin hostWe = 1'b1; hostSel = 1'b0; hostWData = 8'd13; end
      if (c == midAt + 1) begin hostSel = 1'b1; hostWData = 8'(newS & 255); end
      if (c == midAt + 2) begin hostWe = 1'b0; curS = newS; end
      check("R1", "raster address", int'(ra), mr);
      check(mReq, "memory address", int'(ma), (base + mh) & 16383);
      check("R3", "hsync", int'(hSync), (c >= pH2 && ((c - pH2) % lineLen) < wh) ? 1 : 0);
      check("R4", "vsync", int'(vSync), (g >= ls && ((g - ls) % fl) < wv) ? 1 : 0);
      check(dReq, "display enable", int'(dispEn), (mh < pH1 && mv < pV6) ? 1 : 0);
      if (mh == pH0) begin
        mh = 0;
        g++;
        lastBase = base;
        if (mr == pR9) begin
          mr = 0;
          mv = (mv == pV4) ? 0 : mv + 1;
          if (mv != 0) base = (lastBase + pH1) & 16383;
        end else begin
          mr++;
        end
        if (mv == 0) base = curS;
      end else begin
        mh++;
      end
      @(negedge clk);
    end
    rstN = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; hostWe = 1'b0; hostSel = 1'b0; hostWData = '0;
    repeat (3) @(negedge clk);

    // R8: readback masking, constant register, zero reads
    wr(12, 8'hFF); rdChk(12, 8'h3F, "R8");
    wr(13, 8'hA5); rdChk(13, 8'hA5, "R8");
    wr(14, 8'hC7); rdChk(14, 8'h07, "R8");
    wr(15, 8'h5A); rdChk(15, 8'h5A, "R8");
    wr(31, 8'h12); rdChk(31, 8'hFF, "R8");
    wr(20, 8'h77); rdChk(20, 0, "R8");
    wr(0, 8'h33);  rdChk(0, 0, "R8");
    rdChk(16, 0, "R8");
    rdChk(30, 0, "R8");

    // R9: state held in reset
    setCfg(9, 6, 7, 8'h32, 4, 3, 3, 2, 14'h0100);
    check("R9", "reset ra", int'(ra), 0);
    check("R9", "reset ma", int'(ma), 14'h0100);
    check("R9", "reset hsync", int'(hSync), 0);
    check("R9", "reset vsync", int'(vSync), 0);
    check("R9", "reset dispEn", int'(dispEn), 1);
    sweep(300, "R2", "R5", -10, 0);

    // both width fields zero, address wrap
    setCfg(7, 5, 5, 8'h00, 6, 7, 5, 2, 14'h3FF8);
    sweep(504, "R2", "R5", -10, 0);

    // displayed rows zero, wrapping hsync, vsync on row 0
    setCfg(11, 8, 10, 8'h14, 3, 0, 0, 1, 14'h0020);
    sweep(250, "R7", "R5", -10, 0);

    // start address change in the middle of a row-0 line
    setCfg(9, 4, 2, 8'h21, 2, 2, 2, 4, 14'h0200);
    sweep(320, "R2", "R6", 12, 14'h0240);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule